// File: doc/BRIEF.md
# I2C Register-Port Target with Pointer Auto-Increment

This block is a serial two-wire target that gives a host read and write access to a small bank of 8-bit control registers. After the target accepts its device address with the write bit, the host sends a pointer byte. The low seven bits of that byte pick a register index. The top bit selects whether the pointer steps forward after every data byte. Any further bytes in the same transfer are written to the register the pointer selects.

To read, the host writes the address and pointer byte, ends the transfer with STOP, and then sends a new START with the read address. The target shifts out the selected register, most significant bit first. It keeps sending bytes while the host acknowledges and stops at the first host NACK. The pointer survives STOP, so a read transfer always continues from the last pointer value. Both SCL and SDA are sampled through synchronisers on the system clock. SDA is driven as open drain through an enable that pulls the line low.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges only the 7-bit address {10011, strap_a0, 1}. With strap_a0=0 the write byte is 0x9A and the read byte is 0x9B. For any other address it leaves SDA released for the acknowledge bit and for the rest of that transfer.
- R2: In a write transfer, the first byte after the address is acknowledged and loaded as the pointer. Bits 6:0 hold the register index and bit 7 is the step-enable flag.
- R3: Each later byte of a write transfer is acknowledged and written to the register that the pointer selects.
- R4: With the step-enable flag at 0, the pointer stays the same across successive data bytes, for both reads and writes.
- R5: With the step-enable flag at 1, the pointer advances by one after every data byte read or written, and it wraps from index 127 to 0.
- R6: The pointer is kept across STOP. A read transfer returns the register at the pointer, MSB first. A host ACK requests the next byte. A host NACK ends the read, and SDA is left released.
- R7: Index 1 is read-only and reads {00000, REV_ID}, which is 0x05 by default. Writes to it are acknowledged and have no effect.
- R8: Writable bits per index (mask): 2:0x03, 3:0xE7, 5:0x09, 6..9:0xFF, 22:0x58, 23:0x10. Bits outside the mask keep their reset value. Every other index is unimplemented: writes to it are acknowledged and ignored, and reads from it return 0x00.
- R9: After reset, index 3 holds 0x18 and every other register holds 0x00. SDA is released.
- R10: A STOP or START in the middle of a byte aborts that byte without a write. A STOP returns the target to idle, and a START begins a new address phase.
- R11: SDA (sda_oe) changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_a0 | input | 1 | Strap value for address bit 1 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_bank_o | output | NREG*8 | Register contents, index i at bits [8i+7:8i] |

## Verification
The synchroniser adds two system clocks, and edge detection adds a third. Every target response therefore appears within three clocks of the SCL edge that causes it. The bench holds each SCL phase for eight clocks. It samples acknowledge and read bits just before SCL falls, which is well after the target updated SDA on the previous falling edge. A pointer or register update is complete when the acknowledge bit of its byte is sent. The bench therefore checks register contents only after a STOP, and it checks SDA release one full SCL low phase after a host NACK.

// File: rtl/regport_pkg.sv
package regport_pkg;

  localparam logic [4:0] DEV_ADDR_HI = 5'b10011;
  localparam int         PTR_W       = 7;
  localparam int         ID_INDEX    = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK
  } link_st_t;

  // Address byte matches {prefix, strap, 1, rw}
  function automatic logic addr_hit(input logic [7:0] b, input logic a0);
    return b[7:1] == {DEV_ADDR_HI, a0, 1'b1};
  endfunction

  // Pointer advance with natural 7-bit wrap
  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                input logic inc);
    return inc ? p + 7'd1 : p;
  endfunction

  // Writable-bit mask per register index (zero = not stored)
  function automatic logic [7:0] wr_mask(input int idx);
    case (idx)
      2:          return 8'h03;
      3:          return 8'hE7;
      5:          return 8'h09;
      6, 7, 8, 9: return 8'hFF;
      22:         return 8'h58;
      23:         return 8'h10;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] rst_value(input int idx);
    return (idx == 3) ? 8'h18 : 8'h00;
  endfunction

  function automatic logic [7:0] merge_write(input logic [7:0] d,
                                             input logic [7:0] dflt,
                                             input logic [7:0] m);
    return (d & m) | (dflt & ~m);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_p    <= scl_sync[1];
      sda_p    <= sda_sync[1];
    end
  end

  assign scl_q     = scl_sync[1];
  assign sda_q     = sda_sync[1];
  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_det = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_det  = scl_q & scl_p & ~sda_p & sda_q;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
  import regport_pkg::*;
#(
  parameter int         NREG   = 24,
  parameter logic [2:0] REV_ID = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [NREG*8-1:0] bank_flat
);
  logic [7:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [7:0] MASK = wr_mask(i);
    localparam logic [7:0] DFLT = rst_value(i);
    if (MASK != 8'h00) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank[i] <= DFLT;
        else if (wr_en && wr_idx == PTR_W'(i))
          bank[i] <= merge_write(wr_data, DFLT, MASK);
      end
    end else begin : g_const
      assign bank[i] = 8'h00;
    end
    assign bank_flat[i*8 +: 8] = bank[i];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == PTR_W'(i)) rd_data = bank[i];
    if (rd_idx == PTR_W'(ID_INDEX)) rd_data = {5'b00000, REV_ID};
  end
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import regport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_a0,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             incr_q,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_drive,
  output logic             busy,
  output logic             addr_miss,
  output logic             data_adv
);
  link_st_t   state;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic       rw, first, mack;
  logic       byte_end;

  assign byte_end  = scl_fall && cnt == 4'd8 && !start_det && !stop_det;
  assign addr_miss = (state == ST_ADDR) && byte_end && !addr_hit(shreg, strap_a0);
  assign wr_en     = (state == ST_WBYTE) && byte_end && !first;
  assign wr_data   = shreg;
  assign data_adv  = wr_en || ((state == ST_RBYTE) && byte_end);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= 4'd0;
      shreg     <= 8'h00;
      rw        <= 1'b0;
      first     <= 1'b0;
      mack      <= 1'b0;
      ptr       <= '0;
      incr_q    <= 1'b0;
      sda_drive <= 1'b0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      cnt       <= 4'd0;
      sda_drive <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      sda_drive <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WBYTE: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_q};
            cnt   <= cnt + 4'd1;
          end
          if (byte_end) begin
            if (state == ST_ADDR) begin
              if (addr_hit(shreg, strap_a0)) begin
                state     <= ST_AACK;
                sda_drive <= 1'b1;
                rw        <= shreg[0];
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state     <= ST_WACK;
              sda_drive <= 1'b1;
              first     <= 1'b0;
              if (first) begin
                incr_q <= shreg[7];
                ptr    <= shreg[6:0];
              end else begin
                ptr <= ptr_step(ptr, incr_q);
              end
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt <= 4'd0;
          if (rw) begin
            shreg     <= rd_data;
            sda_drive <= ~rd_data[7];
            state     <= ST_RBYTE;
          end else begin
            sda_drive <= 1'b0;
            first     <= 1'b1;
            state     <= ST_WBYTE;
          end
        end
        ST_WACK: if (scl_fall) begin
          sda_drive <= 1'b0;
          cnt       <= 4'd0;
          state     <= ST_WBYTE;
        end
        ST_RBYTE: begin
          if (scl_rise) cnt <= cnt + 4'd1;
          if (byte_end) begin
            sda_drive <= 1'b0;
            state     <= ST_RACK;
            ptr       <= ptr_step(ptr, incr_q);
          end else if (scl_fall) begin
            shreg     <= {shreg[6:0], 1'b0};
            sda_drive <= ~shreg[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_q;
          if (scl_fall) begin
            if (mack) begin
              shreg     <= rd_data;
              sda_drive <= ~rd_data[7];
              cnt       <= 4'd0;
              state     <= ST_RBYTE;
            end else begin
              sda_drive <= 1'b0;
              state     <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import regport_pkg::*;
#(
  parameter int         NREG   = 24,
  parameter logic [2:0] REV_ID = 3'd5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_a0,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [NREG*8-1:0] reg_bank_o
);
  logic             scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic             incr_q, wr_en, busy, addr_miss, data_adv;
  logic [7:0]       wr_data, rd_data;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_link_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .strap_a0(strap_a0), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .ptr(ptr), .incr_q(incr_q),
    .wr_en(wr_en), .wr_data(wr_data), .sda_drive(sda_oe), .busy(busy),
    .addr_miss(addr_miss), .data_adv(data_adv)
  );

  i2c_reg_bank #(.NREG(NREG), .REV_ID(REV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr), .wr_data(wr_data),
    .rd_idx(ptr), .rd_data(rd_data), .bank_flat(reg_bank_o)
  );
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int NREG = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_q,
  input logic             sda_oe,
  input logic             start_det,
  input logic             stop_det,
  input logic             busy,
  input logic             addr_miss,
  input logic             data_adv,
  input logic             incr_q,
  input logic             wr_en,
  input logic [6:0]       ptr,
  input logic [NREG*8-1:0] reg_bank_o
);
  // R1
  miss_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |=> (!sda_oe && !busy));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !busy);

  // R10
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (busy && !sda_oe));

  // R11
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  // R4
  fixed_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_adv && !incr_q) |=> $stable(ptr));

  // R5
  step_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_adv && incr_q) |=> (ptr == $past(ptr) + 7'd1));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_bank_o));
endmodule

bind i2c_regport i2c_regport_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
  .start_det(start_det), .stop_det(stop_det), .busy(busy),
  .addr_miss(addr_miss), .data_adv(data_adv), .incr_q(incr_q),
  .wr_en(wr_en), .ptr(ptr), .reg_bank_o(reg_bank_o)
);

// File: tb/i2c_regport_test.sv
`timescale 1ns/1ps
module i2c_regport_test;
  localparam int NREG = 24;
  localparam int Q    = 8;
  localparam logic [7:0] AW = 8'h9A;
  localparam logic [7:0] AR = 8'h9B;
  localparam logic [7:0] IDV = 8'h05;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] bank;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, viol = 0;
  logic [7:0] mdl [128];
  logic [7:0] rbuf [64];
  logic [7:0] wbuf [64];
  logic prev_oe = 1'b0;

  always #4 clk = ~clk;

  i2c_regport #(.NREG(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .strap_a0(strap), .scl_in(scl_m),
    .sda_in(sda_line), .sda_oe(sda_oe), .reg_bank_o(bank)
  );

  always @(posedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_m) viol++;
    prev_oe <= sda_oe;
  end

  function automatic logic [7:0] m_mask(input int i);
    if (i >= 6 && i <= 9) return 8'hFF;
    if (i == 2) return 8'h03;
    if (i == 3) return 8'hE7;
    if (i == 5) return 8'h09;
    if (i == 22) return 8'h58;
    if (i == 23) return 8'h10;
    return 8'h00;
  endfunction

  function automatic logic [7:0] m_read(input int i);
    return (i == 1) ? IDV : mdl[i];
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_line; scl_m = 1'b0; wq();
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic part_bits(input int n);
    logic r;
    for (int i = 0; i < n; i++) clk_bit(1'b1, r);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); d[i] = r; end
    clk_bit(~mack, r);
  endtask

  task automatic do_write(input logic [7:0] map, input int n);
    logic ack;
    int idx;
    bstart();
    wr_byte(AW, ack);  chk(ack, "R1 write addr ack", {7'd0, ack}, 8'h01);
    wr_byte(map, ack); chk(ack, "R2 pointer ack", {7'd0, ack}, 8'h01);
    idx = int'(map[6:0]);
    for (int k = 0; k < n; k++) begin
      wr_byte(wbuf[k], ack);
      chk(ack, "R3 data ack", {7'd0, ack}, 8'h01);
      mdl[idx] = (wbuf[k] & m_mask(idx)) | (mdl[idx] & ~m_mask(idx));
      if (map[7]) idx = (idx + 1) % 128;
    end
    bstop();
  endtask

  task automatic do_read(input logic [7:0] map, input int n);
    logic ack;
    bstart();
    wr_byte(AW, ack);  chk(ack, "R1 addr ack", {7'd0, ack}, 8'h01);
    wr_byte(map, ack); chk(ack, "R2 pointer ack", {7'd0, ack}, 8'h01);
    bstop();
    bstart();
    wr_byte(AR, ack);  chk(ack, "R6 read addr ack", {7'd0, ack}, 8'h01);
    for (int k = 0; k < n; k++) rd_byte(k != n - 1, rbuf[k]);
    chk(sda_oe == 1'b0, "R6 release after NACK", {7'd0, sda_oe}, 8'h00);
    bstop();
  endtask

  task automatic chk_bank(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(bank[i*8 +: 8] == mdl[i], tag, bank[i*8 +: 8], mdl[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    for (int i = 0; i < 128; i++) mdl[i] = (i == 3) ? 8'h18 : 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: reset state
    chk(sda_oe == 1'b0, "R9 sda released", {7'd0, sda_oe}, 8'h00);
    chk_bank("R9 reset value");

    // R1: address sweep with strap 0
    for (int a = 0; a < 128; a++) begin
      bstart();
      wr_byte({7'(a), 1'b0}, ack);
      chk(ack == (a == 7'h4D), "R1 address match", {7'd0, ack}, {7'd0, a == 7'h4D});
      if (a == 7'h4C) begin
        wr_byte(8'h00, ack);
        chk(!ack, "R1 no drive after miss", {7'd0, ack}, 8'h00);
      end
      bstop();
    end
    // R1: strap moves the matching address
    strap = 1'b1;
    bstart(); wr_byte(8'h9E, ack); bstop();
    chk(ack, "R1 strap=1 match", {7'd0, ack}, 8'h01);
    bstart(); wr_byte(8'h9A, ack); bstop();
    chk(!ack, "R1 strap=1 miss", {7'd0, ack}, 8'h00);
    strap = 1'b0;

    // R3 R5 R7 R8: write indices 0..31 with step enabled
    for (int k = 0; k < 32; k++) wbuf[k] = 8'((k * 37 + 5) ^ 8'hA5);
    do_write(8'h80, 32);
    chk_bank("R8 masked bank after writes");
    // R6 R7 R8: read back indices 0..31
    do_read(8'h80, 32);
    for (int k = 0; k < 32; k++)
      chk(rbuf[k] == m_read(k), "R6 R7 R8 block readback", rbuf[k], m_read(k));

    // R4: fixed pointer writes, then fixed pointer reads
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'hC3;
    do_write(8'h06, 3);
    chk(bank[6*8 +: 8] == 8'hC3, "R4 last write wins", bank[6*8 +: 8], 8'hC3);
    chk(bank[7*8 +: 8] == mdl[7], "R4 neighbour unchanged", bank[7*8 +: 8], mdl[7]);
    do_read(8'h06, 3);
    for (int k = 0; k < 3; k++)
      chk(rbuf[k] == 8'hC3, "R4 fixed read", rbuf[k], 8'hC3);

    // R5: wrap 127 -> 0 -> 1
    do_read(8'hFF, 3);
    chk(rbuf[0] == 8'h00, "R5 index 127", rbuf[0], 8'h00);
    chk(rbuf[1] == 8'h00, "R5 wrap to 0", rbuf[1], 8'h00);
    chk(rbuf[2] == IDV, "R5 wrap then ID", rbuf[2], IDV);

    // R10: STOP mid-byte aborts the write
    bstart(); wr_byte(AW, ack); wr_byte(8'h06, ack);
    part_bits(4); bstop();
    chk(bank[6*8 +: 8] == 8'hC3, "R10 stop abort", bank[6*8 +: 8], 8'hC3);
    // R10: START mid-byte restarts address phase
    bstart(); wr_byte(AW, ack); wr_byte(8'h07, ack);
    part_bits(3); bstart();
    wr_byte(AW, ack);
    chk(ack, "R10 restart addr ack", {7'd0, ack}, 8'h01);
    wr_byte(8'h07, ack); wr_byte(8'h3C, ack); bstop();
    mdl[7] = 8'h3C;
    chk(bank[7*8 +: 8] == 8'h3C, "R10 write after restart", bank[7*8 +: 8], 8'h3C);
    do_read(8'h07, 1);
    chk(rbuf[0] == 8'h3C, "R10 R6 readback", rbuf[0], 8'h3C);
    chk_bank("R8 final bank");

    // R11: SDA only moved while SCL low
    chk(viol == 0, "R11 sda change with scl high", 8'(viol), 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule